// File: doc/BRIEF.md
# Register Readback Selector

This block produces the read response of a memory-mapped register file. Its inputs are the current 32-bit contents of every readable register, a word address and a read strobe. Its outputs are the read word, a one-cycle completion pulse and an error flag. The register file supplies its register values on one flat vector. The bus adapter in front of the block supplies the strobe and the address, and it takes the response two clocks later.

Internally every register is placed in a lookup table, and the table's depth is padded up to a power of two. A slot with no register behind it, and a register left out by the readable-entry mask, returns a configurable default word and raises the error flag. The address picks a table slot in two multiplexer stages with a register between them. The first stage has the smaller fan-in and selects within a group using the low address bits. The second stage selects the group using the high address bits, which are delayed by one cycle so they stay aligned with the first stage. A read can start on every cycle.

The datapath has no state machine. The only sequencing is the two-deep pipeline: idle, then group captured, then response presented. Each strobe advances through it one stage per clock.

Top module: `regfile_readback_mux`

## Requirements
- R1: The table depth is NUM_REGS rounded up to a power of two, and the address width is log2 of that depth. Every address in that range returns a response. The low floor(width/2) address bits select within a group, and the remaining high bits select the group.
- R2: A read of address a, where a < NUM_REGS and bit a of VALID_MASK is 1, returns bits [32a+31:32a] of reg_vals with rd_err low.
- R3: A read of an address at or above NUM_REGS returns DEFAULT_VAL with rd_err high.
- R4: A read of an address below NUM_REGS whose VALID_MASK bit is 0 returns DEFAULT_VAL with rd_err high, whatever the register's contents are.
- R5: rd_done is high for exactly one cycle, two rising edges after the edge that samples rd_en high. rd_data and rd_err are valid in that same cycle.
- R6: rd_en may be high on consecutive cycles. Every strobe produces its own response, in issue order, with no gaps.
- R7: The returned word is the register value present on reg_vals at the edge that samples the strobe. Later changes to reg_vals do not affect that response.
- R8: While rd_done is low, rd_data is zero and rd_err is low.
- R9: An active-low asynchronous reset clears rd_done, rd_err and rd_data at once. Reads in flight when reset asserts produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_vals | input | NUM_REGS*DATA_W | Flattened register contents, register i at bits [DATA_W*i +: DATA_W] |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Read word, zero when no response is presented |
| rd_done | output | 1 | Response pulse, one cycle per strobe |
| rd_err | output | 1 | Read hit an unmapped or unreadable slot |

## Verification
A wrong group word held in the inter-stage register shows up as a wrong rd_data exactly two clocks after the strobe. A stale delayed high-address field shows up the same way, by selecting the neighbouring group. A lost or duplicated stage-valid bit shows as a missing or extra rd_done pulse in the same cycle. A corrupted valid bit flips rd_err against the expected map, and it also swaps the data between the register value and the default word. A full back-to-back sweep followed by long random traffic, with register contents changing under it, checks every response in the one cycle it is presented.

// File: rtl/rbmux_pkg.sv
package rbmux_pkg;

    // Address width needed to index a table padded to a power of two.
    function automatic int tbl_addr_w(input int n_regs);
        return (n_regs <= 2) ? 1 : $clog2(n_regs);
    endfunction

    // Low bits used inside a first-stage group: the smaller half.
    function automatic int grp_lo_w(input int addr_w);
        return (addr_w < 2) ? 1 : addr_w / 2;
    endfunction

endpackage

// File: rtl/rbmux_table.sv
module rbmux_table #(
    parameter int                   NUM_REGS    = 40,
    parameter int                   DATA_W      = 32,
    parameter int                   DEPTH       = 64,
    parameter logic [DATA_W-1:0]    DEFAULT_VAL = '0,
    parameter logic [NUM_REGS-1:0]  VALID_MASK  = '1
) (
    input  logic [NUM_REGS*DATA_W-1:0] reg_vals,
    output logic [DEPTH*DATA_W-1:0]    tbl_data,
    output logic [DEPTH-1:0]           tbl_valid
);

    // Mapped slots carry the raw register word; the valid bit decides later
    // whether the word or the default leaves the block.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i < NUM_REGS) begin : g_map
            assign tbl_data[i*DATA_W +: DATA_W] = reg_vals[i*DATA_W +: DATA_W];
            assign tbl_valid[i]                 = VALID_MASK[i];
        end else begin : g_pad
            assign tbl_data[i*DATA_W +: DATA_W] = DEFAULT_VAL;
            assign tbl_valid[i]                 = 1'b0;
        end
    end

endmodule

// File: rtl/rbmux_stage1.sv
module rbmux_stage1 #(
    parameter int DATA_W  = 32,
    parameter int LO_W    = 3,
    parameter int HI_W    = 3,
    localparam int GRP_SZ  = 2 ** LO_W,
    localparam int NUM_GRP = 2 ** HI_W,
    localparam int DEPTH   = GRP_SZ * NUM_GRP
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [LO_W-1:0]           lo_sel,
    input  logic [HI_W-1:0]           hi_sel,
    input  logic [DEPTH*DATA_W-1:0]   tbl_data,
    input  logic [DEPTH-1:0]          tbl_valid,
    output logic [NUM_GRP*DATA_W-1:0] grp_data_q,
    output logic [NUM_GRP-1:0]        grp_valid_q,
    output logic [HI_W-1:0]           hi_q,
    output logic                      vld_q
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [DATA_W-1:0] pick_data;
        logic              pick_valid;

        always_comb begin
            pick_data  = tbl_data[(g*GRP_SZ + int'(lo_sel))*DATA_W +: DATA_W];
            pick_valid = tbl_valid[g*GRP_SZ + int'(lo_sel)];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp_data_q[g*DATA_W +: DATA_W] <= '0;
                grp_valid_q[g]                 <= 1'b0;
            end else if (rd_en) begin
                grp_data_q[g*DATA_W +: DATA_W] <= pick_data;
                grp_valid_q[g]                 <= pick_valid;
            end
        end
    end

    // Group index travels one cycle behind so it meets the registered groups.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= rd_en;
            if (rd_en) hi_q <= hi_sel;
        end
    end

    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> vld_q); // R6

endmodule

// File: rtl/rbmux_stage2.sv
module rbmux_stage2 #(
    parameter int                DATA_W      = 32,
    parameter int                HI_W        = 3,
    parameter logic [DATA_W-1:0] DEFAULT_VAL = '0,
    localparam int NUM_GRP = 2 ** HI_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      vld_q,
    input  logic [HI_W-1:0]           hi_q,
    input  logic [NUM_GRP*DATA_W-1:0] grp_data_q,
    input  logic [NUM_GRP-1:0]        grp_valid_q,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_done,
    output logic                      rd_err
);

    logic [DATA_W-1:0] sel_data;
    logic              sel_valid;

    always_comb begin
        sel_data  = grp_data_q[int'(hi_q)*DATA_W +: DATA_W];
        sel_valid = grp_valid_q[hi_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_done <= 1'b0;
            rd_err  <= 1'b0;
        end else begin
            rd_done <= vld_q;
            rd_err  <= vld_q & ~sel_valid;
            if (!vld_q)         rd_data <= '0;
            else if (sel_valid) rd_data <= sel_data;
            else                rd_data <= DEFAULT_VAL;
        end
    end

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> rd_done); // R5
    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_done); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |-> (rd_data == '0)); // R8
    AST_ERR_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == DEFAULT_VAL)); // R4

endmodule

// File: rtl/regfile_readback_mux.sv
module regfile_readback_mux #(
    parameter int                   NUM_REGS    = 40,
    parameter int                   DATA_W      = 32,
    parameter logic [DATA_W-1:0]    DEFAULT_VAL = 32'hDEAD_BEEF,
    parameter logic [NUM_REGS-1:0]  VALID_MASK  = '1,
    localparam int ADDR_W = rbmux_pkg::tbl_addr_w(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS*DATA_W-1:0] reg_vals,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_done,
    output logic                       rd_err
);

    localparam int LO_W    = rbmux_pkg::grp_lo_w(ADDR_W);
    localparam int HI_W    = ADDR_W - LO_W;
    localparam int DEPTH   = 2 ** ADDR_W;
    localparam int NUM_GRP = 2 ** HI_W;

    logic [DEPTH*DATA_W-1:0]   tbl_data;
    logic [DEPTH-1:0]          tbl_valid;
    logic [NUM_GRP*DATA_W-1:0] grp_data_q;
    logic [NUM_GRP-1:0]        grp_valid_q;
    logic [HI_W-1:0]           hi_q;
    logic                      vld_q;

    rbmux_table #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DEPTH(DEPTH),
        .DEFAULT_VAL(DEFAULT_VAL), .VALID_MASK(VALID_MASK)
    ) table_i (
        .reg_vals(reg_vals), .tbl_data(tbl_data), .tbl_valid(tbl_valid)
    );

    rbmux_stage1 #(.DATA_W(DATA_W), .LO_W(LO_W), .HI_W(HI_W)) stage1_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .lo_sel(rd_addr[LO_W-1:0]), .hi_sel(rd_addr[ADDR_W-1:LO_W]),
        .tbl_data(tbl_data), .tbl_valid(tbl_valid),
        .grp_data_q(grp_data_q), .grp_valid_q(grp_valid_q),
        .hi_q(hi_q), .vld_q(vld_q)
    );

    rbmux_stage2 #(.DATA_W(DATA_W), .HI_W(HI_W), .DEFAULT_VAL(DEFAULT_VAL)) stage2_i (
        .clk(clk), .rst_n(rst_n), .vld_q(vld_q), .hi_q(hi_q),
        .grp_data_q(grp_data_q), .grp_valid_q(grp_valid_q),
        .rd_data(rd_data), .rd_done(rd_done), .rd_err(rd_err)
    );

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 rd_done); // R5
    AST_PAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_addr) >= NUM_REGS) |=> ##1 rd_err); // R3

endmodule

// File: tb/regfile_readback_mux_tb.sv
module regfile_readback_mux_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 40;
    localparam int DW   = 32;
    localparam int AW   = 6;
    localparam logic [DW-1:0]   DEF  = 32'hDEAD_BEEF;
    localparam logic [NREG-1:0] MASK = 40'hFD_FFFF_FFDF; // slots 5 and 33 unreadable

    typedef struct packed {
        logic          done;
        logic          err;
        logic [DW-1:0] data;
    } resp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NREG*DW-1:0]   reg_vals = '0;
    logic                 rd_en = 1'b0;
    logic [AW-1:0]        rd_addr = '0;
    logic [DW-1:0]        rd_data;
    logic                 rd_done;
    logic                 rd_err;

    int n_cmp = 0;
    int n_bad = 0;
    int done_seen = 0;
    int err_seen = 0;
    resp_t p1 = '0;
    resp_t p2 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regfile_readback_mux #(
        .NUM_REGS(NREG), .DATA_W(DW), .DEFAULT_VAL(DEF), .VALID_MASK(MASK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_vals(reg_vals), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_done(rd_done), .rd_err(rd_err)
    );

    function automatic resp_t expect_rd(input logic en, input int a,
                                        input logic [NREG*DW-1:0] vals);
        resp_t r;
        if (!en)                       r = '0;
        else if (a >= NREG || !MASK[a]) r = '{done: 1'b1, err: 1'b1, data: DEF};
        else                           r = '{done: 1'b1, err: 1'b0, data: vals[a*DW +: DW]};
        return r;
    endfunction

    function automatic string req_of(input resp_t e, input int a);
        if (!e.done)     return "R8";
        if (a >= NREG)   return "R3";
        if (e.err)       return "R4";
        return "R2/R5/R7";
    endfunction

    task automatic cmp(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    int p1_addr = 0;
    int p2_addr = 0;

    // One cycle: check the response due now, then drive the next inputs.
    task automatic step(input logic en, input int a, input bit mutate);
        resp_t act;
        @(negedge clk);
        act = '{done: rd_done, err: rd_err, data: rd_data};
        cmp(act == p2, req_of(p2, p2_addr), "response", 64'(act), 64'(p2));
        if (rd_done) done_seen++;
        if (rd_err)  err_seen++;
        if (mutate) begin
            // R7: contents change under in-flight reads
            int idx = int'($urandom_range(NREG-1, 0));
            reg_vals[idx*DW +: DW] = $urandom;
        end
        rd_en   = en;
        rd_addr = AW'(a);
        p2 = p1; p2_addr = p1_addr;
        p1 = expect_rd(en, a, reg_vals); p1_addr = a;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL R5 watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NREG; i++) reg_vals[i*DW +: DW] = $urandom;
        repeat (3) @(negedge clk);
        cmp(rd_done == 1'b0 && rd_err == 1'b0 && rd_data == '0, "R9", "reset state",
            {31'd0, rd_done, rd_err, rd_data}, 64'd0);
        rst_n = 1'b1;

        // R1 R6: back-to-back sweep of every table slot
        done_seen = 0; err_seen = 0;
        for (int a = 0; a < 2**AW; a++) step(1'b1, a, 1'b0);
        step(1'b0, 0, 1'b0);
        step(1'b0, 0, 1'b0);
        step(1'b0, 0, 1'b0);
        cmp(done_seen == 2**AW, "R6", "done pulses in sweep", 64'(done_seen), 64'(2**AW));
        cmp(err_seen == 26, "R1", "error slots in sweep", 64'(err_seen), 64'd26);

        // Directed corners: masked slots, last mapped, first padded, top slot
        step(1'b1, 5, 1'b0);  step(1'b1, 33, 1'b0);
        step(1'b1, NREG-1, 1'b0); step(1'b1, NREG, 1'b0);
        step(1'b1, 63, 1'b0); step(1'b1, 0, 1'b0);
        step(1'b0, 0, 1'b0);  step(1'b0, 0, 1'b0);

        // Random traffic with changing register contents
        for (int k = 0; k < 3000; k++) begin
            logic en = ($urandom_range(3, 0) != 0);
            int a = int'($urandom_range(2**AW - 1, 0));
            step(en, a, ($urandom_range(1, 0) == 1));
        end

        // R9: reset with reads in flight
        step(1'b1, 3, 1'b0);
        step(1'b1, 7, 1'b0);
        @(negedge clk);
        rd_en = 1'b0;
        rst_n = 1'b0;
        #1;
        cmp(rd_done == 1'b0 && rd_err == 1'b0 && rd_data == '0, "R9", "async clear",
            {31'd0, rd_done, rd_err, rd_data}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        p1 = '0; p2 = '0;
        step(1'b0, 0, 1'b0);
        step(1'b0, 0, 1'b0); // R9: dropped reads give no pulse
        for (int k = 0; k < 200; k++)
            step(1'b1, int'($urandom_range(2**AW - 1, 0)), 1'b1);
        step(1'b0, 0, 1'b0);
        step(1'b0, 0, 1'b0);
        step(1'b0, 0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule